// File: doc/BRIEF.md
# Dual Down-Counter Carrier Generator

The block produces a carrier waveform from two down-counting timers: a narrow one and a wide one. The narrow timer alternates between two programmed counts. One count sets how long its output stays low and the other sets how long it stays high, so a single timer yields a carrier with a freely chosen duty cycle. The wide timer reloads from a single count, so its output is a symmetric square wave, or a single timed interval. Each timer can repeat (modulo-N) or stop after one interval (single-pass). Each has a sticky timeout flag and an interrupt pulse.

In ping-pong mode the two timers take turns. When the running timer reaches its terminal count, the hardware stops it and starts the other one. This chains a burst from one timer with a gap from the other, with no software involvement. Software starts the chain by stopping both timers, configuring them, and then setting either enable. Clearing the ping-pong select returns both timers to independent operation.

All control and status pins are plain levels or single-cycle pulses. Hold values are read only when a timer loads, so they may be rewritten while the timer is counting.

Top module: `carrier_pair_gen`

## Requirements
- R1: The enable of a timer rises on the clock edge after a set pulse, when the timer is idle and no clear pulse is present, or on a ping-pong handoff. On that same edge the timer output takes the programmed initial level. The narrow timer loads its low-level hold when that level is 0 and its high-level hold when it is 1. A set pulse while the timer is already enabled has no effect.
- R2: In modulo-N mode, the narrow timer output holds each level for exactly the count held for that level (low hold for 0, high hold for 1), then toggles and reloads for the new level, indefinitely.
- R3: In single-pass mode, the enable clears on the terminal-count edge, N cycles after the load. The narrow output toggles once on that edge and then holds.
- R4: A hold value of 0 gives a full period of 2^W cycles. For the narrow timer with default parameters that is 256 cycles.
- R5: While the wide timer is disabled, its output equals its initial-level input. While it is enabled in modulo-N mode, it toggles every N cycles, where N is its hold value.
- R6: Each timer's timeout flag is set on every terminal-count edge and stays set until a timeout-clear pulse. If the set and the clear fall on the same edge, the set wins.
- R7: An interrupt is a one-cycle pulse that is high in the cycle after a terminal-count edge. It occurs only if that timer's interrupt enable was high during the terminal cycle.
- R8: With ping-pong selected, both timers behave as single-pass regardless of their mode inputs. On a timer's terminal-count edge its enable clears and the other timer's enable sets and loads.
- R9: With ping-pong deselected, a terminal count never starts the other timer.
- R10: A hold value written while a timer is counting does not change the current interval. It takes effect at the next load.
- R11: A clear pulse drops the enable on the next edge and freezes the narrow output at its present level. A clear pulse beats a simultaneous set pulse.
- R12: After reset both enables, both timeout flags, both interrupts and the narrow output are 0. The wide output shows its initial-level input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t8_hi_hold | input | W8 | Narrow timer count for the high level |
| t8_lo_hold | input | W8 | Narrow timer count for the low level |
| t16_hold | input | W16 | Wide timer count |
| t8_init_lvl | input | 1 | Narrow timer output level at load |
| t16_init_lvl | input | 1 | Wide timer output level at load and while idle |
| t8_cont | input | 1 | Narrow timer: 1 modulo-N, 0 single-pass |
| t16_cont | input | 1 | Wide timer: 1 modulo-N, 0 single-pass |
| pingpong | input | 1 | 1 selects ping-pong, 0 independent operation |
| t8_en_set | input | 1 | Pulse: start narrow timer |
| t8_en_clr | input | 1 | Pulse: stop narrow timer |
| t16_en_set | input | 1 | Pulse: start wide timer |
| t16_en_clr | input | 1 | Pulse: stop wide timer |
| t8_tmo_clr | input | 1 | Pulse: clear narrow timeout flag |
| t16_tmo_clr | input | 1 | Pulse: clear wide timeout flag |
| t8_irq_en | input | 1 | Narrow timer interrupt enable |
| t16_irq_en | input | 1 | Wide timer interrupt enable |
| t8_out | output | 1 | Narrow timer output |
| t16_out | output | 1 | Wide timer output |
| t8_en | output | 1 | Narrow timer enable state |
| t16_en | output | 1 | Wide timer enable state |
| t8_tmo | output | 1 | Narrow timer timeout flag |
| t16_tmo | output | 1 | Wide timer timeout flag |
| t8_irq | output | 1 | Narrow timer interrupt pulse |
| t16_irq | output | 1 | Wide timer interrupt pulse |

## Verification
Random phases draw short hold values and mixed mode, initial-level and ping-pong settings. They also pulse the set, clear and timeout-clear inputs at random, and rewrite the holds while the timers count. This separates the reload taken at load time from the reload taken at terminal count, and the set-versus-clear priorities. Directed cases cover the remaining corners. A zero hold must stretch one level to 256 cycles, which catches an early terminal count. A ping-pong chain must alternate the two enables, which catches missing or doubled handoffs. Dropping ping-pong mid-chain must stop the chain after the running interval. A clear in the middle of a level must freeze the output at that level.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef struct packed {
    logic load;
    logic run;
  } tmr_ctl_t;
  localparam int unsigned NUM_TMR = 2;
  localparam int unsigned IDX_NARROW = 0;
  localparam int unsigned IDX_WIDE = 1;
endpackage

// File: rtl/cg_down_timer.sv
module cg_down_timer
  import cg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_ctl_t     ctl,
  input  logic [W-1:0] hold_lo,
  input  logic [W-1:0] hold_hi,
  input  logic         init_lvl,
  output logic         out_q,
  output logic         tc
);
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  // terminal cycle: running with one count left
  assign tc = ctl.run & (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (ctl.load) begin
      out_q <= init_lvl;
      cnt_q <= init_lvl ? hold_hi : hold_lo;
    end else if (ctl.run) begin
      if (cnt_q == CNT_ONE) begin
        out_q <= ~out_q;
        cnt_q <= out_q ? hold_lo : hold_hi;
      end else begin
        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/cg_enable_ctl.sv
module cg_enable_ctl
  import cg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pingpong,
  input  logic [NUM_TMR-1:0] en_set,
  input  logic [NUM_TMR-1:0] en_clr,
  input  logic [NUM_TMR-1:0] cont,
  input  logic [NUM_TMR-1:0] tc,
  output logic [NUM_TMR-1:0] en_q,
  output logic [NUM_TMR-1:0] start
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_en
    localparam int unsigned OTHER = NUM_TMR - 1 - i;
    logic stop_i;

    assign start[i] = (~en_q[i] & en_set[i] & ~en_clr[i]) | (pingpong & tc[OTHER]);
    assign stop_i   = en_clr[i] | (tc[i] & (pingpong | ~cont[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q[i] <= 1'b0;
      else if (start[i])   en_q[i] <= 1'b1;
      else if (stop_i)     en_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cg_status.sv
module cg_status
  import cg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] tc,
  input  logic [NUM_TMR-1:0] tmo_clr,
  input  logic [NUM_TMR-1:0] irq_en,
  output logic [NUM_TMR-1:0] tmo_q,
  output logic [NUM_TMR-1:0] irq_q
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_st
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmo_q[i] <= 1'b0;
        irq_q[i] <= 1'b0;
      end else begin
        irq_q[i] <= tc[i] & irq_en[i];
        if (tc[i])            tmo_q[i] <= 1'b1;
        else if (tmo_clr[i])  tmo_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/carrier_pair_gen.sv
module carrier_pair_gen
  import cg_pkg::*;
#(
  parameter int unsigned W8  = 8,
  parameter int unsigned W16 = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W8-1:0]  t8_hi_hold,
  input  logic [W8-1:0]  t8_lo_hold,
  input  logic [W16-1:0] t16_hold,
  input  logic           t8_init_lvl,
  input  logic           t16_init_lvl,
  input  logic           t8_cont,
  input  logic           t16_cont,
  input  logic           pingpong,
  input  logic           t8_en_set,
  input  logic           t8_en_clr,
  input  logic           t16_en_set,
  input  logic           t16_en_clr,
  input  logic           t8_tmo_clr,
  input  logic           t16_tmo_clr,
  input  logic           t8_irq_en,
  input  logic           t16_irq_en,
  output logic           t8_out,
  output logic           t16_out,
  output logic           t8_en,
  output logic           t16_en,
  output logic           t8_tmo,
  output logic           t16_tmo,
  output logic           t8_irq,
  output logic           t16_irq
);
  logic [NUM_TMR-1:0] en_q, start, tc, tmo_q, irq_q;
  logic               w_q;
  tmr_ctl_t           ctl_n, ctl_w;

  cg_enable_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pingpong (pingpong),
    .en_set   ({t16_en_set, t8_en_set}),
    .en_clr   ({t16_en_clr, t8_en_clr}),
    .cont     ({t16_cont, t8_cont}),
    .tc       (tc),
    .en_q     (en_q),
    .start    (start)
  );

  assign ctl_n = '{load: start[IDX_NARROW], run: en_q[IDX_NARROW]};
  assign ctl_w = '{load: start[IDX_WIDE],   run: en_q[IDX_WIDE]};

  cg_down_timer #(.W(W8)) u_narrow (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl_n),
    .hold_lo  (t8_lo_hold),
    .hold_hi  (t8_hi_hold),
    .init_lvl (t8_init_lvl),
    .out_q    (t8_out),
    .tc       (tc[IDX_NARROW])
  );

  cg_down_timer #(.W(W16)) u_wide (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl_w),
    .hold_lo  (t16_hold),
    .hold_hi  (t16_hold),
    .init_lvl (t16_init_lvl),
    .out_q    (w_q),
    .tc       (tc[IDX_WIDE])
  );

  cg_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .tc      (tc),
    .tmo_clr ({t16_tmo_clr, t8_tmo_clr}),
    .irq_en  ({t16_irq_en, t8_irq_en}),
    .tmo_q   (tmo_q),
    .irq_q   (irq_q)
  );

  assign t16_out = en_q[IDX_WIDE] ? w_q : t16_init_lvl;
  assign t8_en   = en_q[IDX_NARROW];
  assign t16_en  = en_q[IDX_WIDE];
  assign t8_tmo  = tmo_q[IDX_NARROW];
  assign t16_tmo = tmo_q[IDX_WIDE];
  assign t8_irq  = irq_q[IDX_NARROW];
  assign t16_irq = irq_q[IDX_WIDE];
endmodule

// File: rtl/carrier_pair_chk.sv
module carrier_pair_chk (
  input logic clk,
  input logic rst_n,
  input logic pingpong,
  input logic t8_init_lvl,
  input logic t8_en_clr,
  input logic t16_en_clr,
  input logic t8_irq_en,
  input logic t16_irq_en,
  input logic t8_out,
  input logic t8_en,
  input logic t16_en,
  input logic t8_tmo,
  input logic t16_tmo,
  input logic t8_irq,
  input logic t16_irq
);
  AST_LOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t8_en) |-> t8_out == $past(t8_init_lvl)); // R1

  AST_SINGLE_STOP_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(t16_en) && !$past(t16_en_clr)) |-> t16_tmo); // R3

  AST_IRQ_WITH_TMO_N: assert property (@(posedge clk) disable iff (!rst_n)
    t8_irq |-> t8_tmo); // R6

  AST_IRQ_WITH_TMO_W: assert property (@(posedge clk) disable iff (!rst_n)
    t16_irq |-> t16_tmo); // R6

  AST_IRQ_MASKED_N: assert property (@(posedge clk) disable iff (!rst_n)
    t8_irq |-> $past(t8_irq_en)); // R7

  AST_IRQ_MASKED_W: assert property (@(posedge clk) disable iff (!rst_n)
    t16_irq |-> $past(t16_irq_en)); // R7

  AST_PP_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pingpong) && $fell(t8_en) && !$past(t8_en_clr)) |-> t16_en); // R8
endmodule

bind carrier_pair_gen carrier_pair_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pingpong    (pingpong),
  .t8_init_lvl (t8_init_lvl),
  .t8_en_clr   (t8_en_clr),
  .t16_en_clr  (t16_en_clr),
  .t8_irq_en   (t8_irq_en),
  .t16_irq_en  (t16_irq_en),
  .t8_out      (t8_out),
  .t8_en       (t8_en),
  .t16_en      (t16_en),
  .t8_tmo      (t8_tmo),
  .t16_tmo     (t16_tmo),
  .t8_irq      (t8_irq),
  .t16_irq     (t16_irq)
);

// File: tb/sim_carrier_pair_gen.sv
`timescale 1ns/1ps
module sim_carrier_pair_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  hi8 = '0, lo8 = '0;
  logic [15:0] h16 = '0;
  logic init8 = 0, init16 = 0, cont8 = 0, cont16 = 0, pp = 0;
  logic set8 = 0, clr8 = 0, set16 = 0, clr16 = 0, tclr8 = 0, tclr16 = 0;
  logic ie8 = 0, ie16 = 0;
  logic o8, o16, e8, e16, tm8, tm16, iq8, iq16;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit me8, me16, mo8, mo16, mt8, mt16, mi8, mi16;
  int left8, left16;

  always #2 clk = ~clk;

  carrier_pair_gen u0 (
    .clk(clk), .rst_n(rst_n), .t8_hi_hold(hi8), .t8_lo_hold(lo8), .t16_hold(h16),
    .t8_init_lvl(init8), .t16_init_lvl(init16), .t8_cont(cont8), .t16_cont(cont16),
    .pingpong(pp), .t8_en_set(set8), .t8_en_clr(clr8), .t16_en_set(set16),
    .t16_en_clr(clr16), .t8_tmo_clr(tclr8), .t16_tmo_clr(tclr16),
    .t8_irq_en(ie8), .t16_irq_en(ie16), .t8_out(o8), .t16_out(o16),
    .t8_en(e8), .t16_en(e16), .t8_tmo(tm8), .t16_tmo(tm16), .t8_irq(iq8), .t16_irq(iq16)
  );

  function automatic int span(input int h, input int full);
    return (h == 0) ? full : h;
  endfunction

  function automatic string pick(input string tag, input string dflt);
    return (tag == "") ? dflt : tag;
  endfunction

  // reference model stepped on each rising edge from requirement rules
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me8 = 0; me16 = 0; mo8 = 0; mo16 = 0; mt8 = 0; mt16 = 0; mi8 = 0; mi16 = 0;
      left8 = 0; left16 = 0;
    end else begin
      bit tc8, tc16, st8, st16, sp8, sp16;
      tc8  = me8  && left8  == 1;
      tc16 = me16 && left16 == 1;
      st8  = (!me8  && set8  && !clr8)  || (pp && tc16);
      st16 = (!me16 && set16 && !clr16) || (pp && tc8);
      sp8  = clr8  || (tc8  && (pp || !cont8));
      sp16 = clr16 || (tc16 && (pp || !cont16));
      if (st8) begin
        mo8 = init8; left8 = init8 ? span(hi8, 256) : span(lo8, 256);
      end else if (me8) begin
        if (tc8) begin mo8 = !mo8; left8 = mo8 ? span(hi8, 256) : span(lo8, 256); end
        else left8 = left8 - 1;
      end
      if (st16) begin
        mo16 = init16; left16 = span(h16, 65536);
      end else if (me16) begin
        if (tc16) begin mo16 = !mo16; left16 = span(h16, 65536); end
        else left16 = left16 - 1;
      end
      me8  = st8  ? 1'b1 : (sp8  ? 1'b0 : me8);
      me16 = st16 ? 1'b1 : (sp16 ? 1'b0 : me16);
      mt8  = tc8  ? 1'b1 : (tclr8  ? 1'b0 : mt8);
      mt16 = tc16 ? 1'b1 : (tclr16 ? 1'b0 : mt16);
      mi8  = tc8 && ie8;
      mi16 = tc16 && ie16;
    end
  end

  task automatic chk1(input string req, input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk1(pick(tag, "R2"), "t8_out",  o8,   mo8);
    chk1(pick(tag, "R5"), "t16_out", o16,  me16 ? mo16 : init16);
    chk1(pick(tag, "R3"), "t8_en",   e8,   me8);
    chk1(pick(tag, "R3"), "t16_en",  e16,  me16);
    chk1(pick(tag, "R6"), "t8_tmo",  tm8,  mt8);
    chk1(pick(tag, "R6"), "t16_tmo", tm16, mt16);
    chk1(pick(tag, "R7"), "t8_irq",  iq8,  mi8);
    chk1(pick(tag, "R7"), "t16_irq", iq16, mi16);
  endtask

  task automatic cyc(input string tag);
    @(posedge clk); @(negedge clk);
    compare(tag);
    set8 = 0; clr8 = 0; set16 = 0; clr16 = 0; tclr8 = 0; tclr16 = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int cnt;
    logic frozen;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk1("R12", "t8_out", o8, 1'b0);
    chk1("R12", "t16_out", o16, init16);
    chk1("R12", "t8_en", e8, 1'b0);
    chk1("R12", "t16_en", e16, 1'b0);
    chk1("R12", "t8_tmo", tm8, 1'b0);
    chk1("R12", "t16_irq", iq16, 1'b0);

    // R4: zero low hold stretches level 0 to 256 cycles
    lo8 = 0; hi8 = 3; init8 = 0; cont8 = 1; ie8 = 1; set8 = 1;
    cyc("R1");
    cnt = 0;
    while (o8 == 1'b0 && cnt < 300) begin cnt++; cyc("R4"); end
    n_chk++;
    if (cnt != 256) begin n_bad++; $display("FAIL R4 low span: got %0d expected 256", cnt); end
    repeat (10) cyc("R2");

    // R11: clear freezes narrow output
    clr8 = 1; set8 = 1;
    cyc("R11");
    frozen = o8;
    repeat (8) begin
      cyc("R11");
      chk1("R11", "t8_out frozen", o8, frozen);
    end

    // R8: ping-pong chain
    tclr8 = 1; tclr16 = 1; cyc("R6");
    pp = 1; cont8 = 1; cont16 = 1; lo8 = 3; hi8 = 2; init8 = 1; h16 = 4; init16 = 0;
    ie16 = 1; set8 = 1;
    repeat (40) cyc("R8");
    // R9: drop ping-pong, chain stops
    pp = 0; cont8 = 0; cont16 = 0;
    repeat (20) cyc("R9");
    chk1("R9", "t8_en idle", e8, 1'b0);
    chk1("R9", "t16_en idle", e16, 1'b0);

    // R10: rewrite hold mid-count
    h16 = 6; cont16 = 1; init16 = 1; set16 = 1;
    cyc("R1");
    repeat (2) cyc("R10");
    h16 = 2;
    repeat (16) cyc("R10");
    clr16 = 1; cyc("R11");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 15) == 0) begin
        hi8 = 8'($urandom_range(1, 6));
        lo8 = 8'($urandom_range(1, 6));
        h16 = 16'($urandom_range(1, 9));
        init8 = 1'($urandom); init16 = 1'($urandom);
        cont8 = 1'($urandom); cont16 = 1'($urandom);
        ie8 = 1'($urandom); ie16 = 1'($urandom);
      end
      if ($urandom_range(0, 63) == 0) pp = 1'($urandom);
      set8   = ($urandom_range(0, 7) == 0);
      set16  = ($urandom_range(0, 7) == 0);
      clr8   = ($urandom_range(0, 29) == 0);
      clr16  = ($urandom_range(0, 29) == 0);
      tclr8  = ($urandom_range(0, 9) == 0);
      tclr16 = ($urandom_range(0, 9) == 0);
      cyc("");
    end
    done = 1;
    finish_run();
  end
endmodule